// File: doc/BRIEF.md
# Opcode-Encoded Single-Bit Operation Unit

This unit carries out one instruction at a time from a family of single-bit operations. The opcode byte itself holds the bit number and the operation, so no mask operand is needed. There are four operations: force a bit to one, force a bit to zero, branch when a bit is one, and branch when a bit is zero. Each operation works on either the accumulator or one byte of the zero page. A zero-page update is a read-modify-write on a simple memory port. A zero-page test reads the byte and leaves it unchanged. The unit does not fetch opcodes or operands. An upstream sequencer supplies the opcode, the zero-page address, the signed branch offset, the address of the next instruction and the current accumulator.

Commands arrive on a valid/ready channel. A command is taken on a clock edge where both `in_valid` and `in_ready` are high. The producer must hold every `in_*` field steady while `in_valid` is high and `in_ready` is low. Results leave on a second valid/ready channel. While `out_valid` is high and `out_ready` is low, the unit holds every `out_*` field unchanged. The result fields have meaning only while `out_valid` is high. Only one command is in flight at a time, so `in_ready` stays low from acceptance until the result has been handed off.

The memory port has a fixed read latency. `mem_rdata` must carry the addressed byte in the cycle right after the cycle in which `mem_rd` is high. A write takes effect at the clock edge where `mem_wr` is high.

Top module: `bmu_core`

## Requirements
- R1: An opcode is legal only when bit 3 is 0 and bits [1:0] are 11 (set/clear) or 00 (test-branch). Any other opcode gives a result with `out_illegal`=1, `out_taken`=0, `out_target_pc` equal to `in_next_pc`, `out_acc` equal to `in_acc`, and no memory cycle.
- R2: For a legal set/clear opcode with bit 2 = 0, `out_acc` is `in_acc` with bit `opcode[7:5]` forced to 1 when `opcode[4]`=0, or forced to 0 when `opcode[4]`=1. All other bits pass through unchanged.
- R3: For a legal set/clear opcode with bit 2 = 1, the unit issues one read of `in_zp_addr`. It then issues one write to the same address, two cycles after the read. The written byte differs from the byte read only in bit `opcode[7:5]`, which becomes 1 if `opcode[4]`=0 and 0 if `opcode[4]`=1.
- R4: For a legal test-branch opcode with bit 2 = 1, the unit issues exactly one read of `in_zp_addr` and no write. Memory is left unchanged.
- R5: For a legal test-branch opcode, `out_taken`=1 exactly when bit `opcode[7:5]` of the operand equals NOT `opcode[4]`. The operand is `in_acc` when bit 2 = 0 and the zero-page byte when bit 2 = 1.
- R6: When `out_taken`=1, `out_target_pc` is `in_next_pc` plus the sign-extended `in_offset`, wrapping modulo 2^PC_W. Otherwise it equals `in_next_pc`. Set/clear opcodes always give `out_taken`=0.
- R7: Every opcode except an accumulator set/clear returns `out_acc` equal to `in_acc`, and `out_illegal`=0 for every legal opcode.
- R8: `in_ready` is high only while no command is in flight and no result is waiting. `in_ready` and `out_valid` are never high together.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and every result field stays stable.
- R10: `out_valid` first goes high after a set number of clock edges, counted from the edge that accepts the command. The count is 1 edge for illegal and accumulator opcodes, 3 edges for a zero-page test and 4 edges for a zero-page set/clear.
- R11: After reset, `in_ready`=1, `out_valid`=0, `mem_rd`=0 and `mem_wr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Unit can accept a command |
| in_opcode | input | 8 | Opcode byte (bit number, sense, target, kind) |
| in_zp_addr | input | ZP_AW | Zero-page byte address |
| in_offset | input | OFF_W | Signed branch displacement |
| in_next_pc | input | PC_W | Address of the following instruction |
| in_acc | input | 8 | Current accumulator value |
| mem_addr | output | ZP_AW | Memory address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_acc | output | 8 | Accumulator after the instruction |
| out_taken | output | 1 | Branch taken |
| out_target_pc | output | PC_W | Next program counter |
| out_illegal | output | 1 | Opcode is outside the family |

## Verification
The result is due 1, 3 or 4 edges after acceptance, depending on whether the opcode is an accumulator or illegal one, a zero-page test, or a zero-page update. The bench records the cycle count at the accepting edge and stores the expected delay with each queued item. The monitor samples on falling edges and compares the elapsed count when it first sees `out_valid`. It also counts read and write strobes for each command, so the memory traffic is checked along with the timing. Some results are held back with `out_ready` low, and the monitor confirms the fields stay unchanged until it pops the item.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int BMU_BIT_W  = 3;
  localparam int BMU_DATA_W = 1 << BMU_BIT_W;

  typedef struct packed {
    logic                 legal;
    logic                 branch;  // test-branch kind
    logic                 clr;     // clear / branch-if-clear sense
    logic                 zp;      // zero-page target
    logic [BMU_BIT_W-1:0] bitn;
  } bmu_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CAP,
    ST_WR,
    ST_DONE
  } bmu_state_e;

  function automatic bmu_dec_t bmu_decode_op(input logic [7:0] op);
    bmu_dec_t d;
    d.bitn   = op[7:5];
    d.clr    = op[4];
    d.zp     = op[2];
    d.branch = (op[1:0] == 2'b00);
    d.legal  = !op[3] && ((op[1:0] == 2'b00) || (op[1:0] == 2'b11));
    return d;
  endfunction

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [7:0] opcode,
  output bmu_dec_t   dec
);

  always_comb dec = bmu_decode_op(opcode);

endmodule

// File: rtl/bmu_bitop.sv
module bmu_bitop #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [BIT_W-1:0]  bitn,
  input  logic              clr,
  output logic [DATA_W-1:0] modified,
  output logic              bit_val
);

  logic [DATA_W-1:0] sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign sel[i]      = (bitn == BIT_W'(i));
    assign modified[i] = sel[i] ? ~clr : operand[i];
  end

  assign bit_val = |(operand & sel);

endmodule

// File: rtl/bmu_fsm.sv
module bmu_fsm
  import bmu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic need_mem,   // judged on the accepting cycle
  input  logic need_wr,    // judged in the capture cycle
  input  logic out_ready,
  output logic in_ready,
  output logic mem_rd,
  output logic mem_wr,
  output logic capture,
  output logic out_valid
);

  bmu_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept) st_nx = need_mem ? ST_RD : ST_DONE;
      ST_RD:   st_nx = ST_CAP;
      ST_CAP:  st_nx = need_wr ? ST_WR : ST_DONE;
      ST_WR:   st_nx = ST_DONE;
      ST_DONE: if (out_ready) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign in_ready  = (st == ST_IDLE);
  assign mem_rd    = (st == ST_RD);
  assign capture   = (st == ST_CAP);
  assign mem_wr    = (st == ST_WR);
  assign out_valid = (st == ST_DONE);

endmodule

// File: rtl/bmu_core.sv
module bmu_core
  import bmu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int ZP_AW = 8,
  parameter int OFF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_opcode,
  input  logic [ZP_AW-1:0]      in_zp_addr,
  input  logic [OFF_W-1:0]      in_offset,
  input  logic [PC_W-1:0]       in_next_pc,
  input  logic [BMU_DATA_W-1:0] in_acc,
  output logic [ZP_AW-1:0]      mem_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [BMU_DATA_W-1:0] mem_wdata,
  input  logic [BMU_DATA_W-1:0] mem_rdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [BMU_DATA_W-1:0] out_acc,
  output logic                  out_taken,
  output logic [PC_W-1:0]       out_target_pc,
  output logic                  out_illegal
);

  localparam int EXT_W = PC_W - OFF_W;

  bmu_dec_t              dec_in, cmd_q;
  logic [ZP_AW-1:0]      zp_q;
  logic [OFF_W-1:0]      off_q;
  logic [PC_W-1:0]       pc_q;
  logic [BMU_DATA_W-1:0] acc_q, data_q, operand, modified;
  logic                  accept, capture, bit_val, taken;
  logic [PC_W-1:0]       off_ext;

  bmu_decode u_dec (
    .opcode (in_opcode),
    .dec    (dec_in)
  );

  assign accept = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      zp_q   <= '0;
      off_q  <= '0;
      pc_q   <= '0;
      acc_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        cmd_q <= dec_in;
        zp_q  <= in_zp_addr;
        off_q <= in_offset;
        pc_q  <= in_next_pc;
        acc_q <= in_acc;
      end
      if (capture) data_q <= mem_rdata;
    end
  end

  bmu_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .need_mem  (dec_in.legal & dec_in.zp),
    .need_wr   (~cmd_q.branch),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .capture   (capture),
    .out_valid (out_valid)
  );

  assign operand = cmd_q.zp ? data_q : acc_q;

  bmu_bitop #(.DATA_W(BMU_DATA_W)) u_bit (
    .operand  (operand),
    .bitn     (cmd_q.bitn),
    .clr      (cmd_q.clr),
    .modified (modified),
    .bit_val  (bit_val)
  );

  assign mem_addr  = zp_q;
  assign mem_wdata = modified;

  assign taken   = cmd_q.legal & cmd_q.branch & (bit_val != cmd_q.clr);
  assign off_ext = {{EXT_W{off_q[OFF_W-1]}}, off_q};

  assign out_taken     = taken;
  assign out_target_pc = taken ? pc_q + off_ext : pc_q;
  assign out_acc       = (cmd_q.legal & ~cmd_q.branch & ~cmd_q.zp) ? modified : acc_q;
  assign out_illegal   = ~cmd_q.legal;

endmodule

// File: rtl/bmu_core_chk.sv
module bmu_core_chk #(
  parameter int PC_W  = 16,
  parameter int ZP_AW = 8,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [ZP_AW-1:0] mem_addr,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [7:0]       mem_wdata,
  input logic [7:0]       mem_rdata,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_acc,
  input logic             out_taken,
  input logic [PC_W-1:0]  out_target_pc,
  input logic             out_illegal
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));  // R3

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));  // R3

  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr, 2)));  // R3

  AST_WR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));  // R3

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);  // R4

  AST_ILLEGAL_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_taken);  // R1

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));  // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_taken)
                                   && $stable(out_target_pc) && $stable(out_illegal)));  // R9

endmodule

bind bmu_core bmu_core_chk #(.PC_W(PC_W), .ZP_AW(ZP_AW), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/test_bmu_core.sv
module test_bmu_core;

  localparam int PC_W = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_opcode = 0;
  logic [7:0]  in_zp_addr = 0;
  logic [7:0]  in_offset = 0;
  logic [15:0] in_next_pc = 0;
  logic [7:0]  in_acc = 0;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [7:0]  out_acc;
  logic        out_taken;
  logic [15:0] out_target_pc;
  logic        out_illegal;

  always #5 clk = ~clk;

  bmu_core i_bmu_core (.*);

  // memory model and shadow copy
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int cyc = 0, rd_cnt = 0, wr_cnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
  end

  typedef struct {
    logic [7:0]  acc;
    logic        taken;
    logic [15:0] tgt;
    logic        ill;
    int          lat, rds, wrs;
    bit          stall;
  } exp_t;

  exp_t q[$];
  int acc_cyc, acc_rd, acc_wr;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] zp, input logic [7:0] off,
                      input logic [15:0] pc, input logic [7:0] acc, input bit stall);
    exp_t e;
    int   b = op[7:5];
    bit   clr = op[4], onzp = op[2];
    bit   legal = !op[3] && (op[1:0] == 2'b00 || op[1:0] == 2'b11);
    bit   br = (op[1:0] == 2'b00);
    logic [7:0] opnd, nv;
    e.acc = acc; e.taken = 0; e.tgt = pc; e.ill = !legal;
    e.lat = 1; e.rds = 0; e.wrs = 0; e.stall = stall;
    if (legal) begin
      opnd = onzp ? shadow[zp] : acc;
      nv = opnd; nv[b] = !clr;
      if (onzp) begin e.rds = 1; e.lat = br ? 3 : 4; end
      if (br) begin
        e.taken = (opnd[b] == !clr);
        if (e.taken) e.tgt = pc + {{8{off[7]}}, off};
      end else if (onzp) begin
        shadow[zp] = nv; e.wrs = 1;
      end else e.acc = nv;
    end
    q.push_back(e);
    @(negedge clk);
    in_valid = 1; in_opcode = op; in_zp_addr = zp; in_offset = off;
    in_next_pc = pc; in_acc = acc;
    while (!in_ready) @(negedge clk);
    acc_cyc = cyc; acc_rd = rd_cnt; acc_wr = wr_cnt;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_opcode = 8'h5A;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic [7:0] a0; logic t0; logic [15:0] p0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && q.size() != 0) begin
        e = q[0];
        chk(cyc - acc_cyc == e.lat, "R10", "latency", cyc - acc_cyc, e.lat);
        if (e.stall) begin
          out_ready = 0;
          a0 = out_acc; t0 = out_taken; p0 = out_target_pc;
          repeat (2) @(negedge clk);
          chk(out_valid && out_acc == a0 && out_taken == t0 && out_target_pc == p0,
              "R9", "hold under stall", {out_valid, out_acc}, {1'b1, a0});
          out_ready = 1;
        end
        chk(out_acc == e.acc, e.ill ? "R1" : "R2/R7", "acc", out_acc, e.acc);
        chk(out_taken == e.taken, "R5", "taken", out_taken, e.taken);
        chk(out_target_pc == e.tgt, "R6", "target", out_target_pc, e.tgt);
        chk(out_illegal == e.ill, "R1", "illegal", out_illegal, e.ill);
        chk(rd_cnt - acc_rd == e.rds, "R4", "reads", rd_cnt - acc_rd, e.rds);
        chk(wr_cnt - acc_wr == e.wrs, "R3", "writes", wr_cnt - acc_wr, e.wrs);
        chk(!in_ready, "R8", "ready while result pending", in_ready, 0);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37) ^ 8'h5A;
      shadow[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(in_ready && !out_valid && !mem_rd && !mem_wr, "R11", "reset outputs",
        {in_ready, out_valid, mem_rd, mem_wr}, 4'b1000);
    rst_n = 1;

    send(8'h03, 8'h00, 8'h00, 16'h1000, 8'h00, 0);  // acc set bit0     R2
    send(8'hF3, 8'h00, 8'h00, 16'h1000, 8'hFF, 0);  // acc clear bit7   R2
    send(8'h73, 8'h00, 8'h00, 16'h1000, 8'hFF, 1);  // acc clear bit3, stall R9
    send(8'hA7, 8'h10, 8'h00, 16'h2000, 8'h33, 0);  // zp set bit5      R3
    send(8'h57, 8'h20, 8'h00, 16'h2000, 8'h44, 1);  // zp clear bit2    R3
    send(8'h27, 8'h10, 8'h00, 16'h2000, 8'h44, 0);  // zp set, bit1     R3
    send(8'h80, 8'h00, 8'h10, 16'h3000, 8'h10, 0);  // acc bbs bit4 taken  R5 R6
    send(8'h90, 8'h00, 8'h10, 16'h3000, 8'h10, 0);  // acc bbc bit4 not taken R5
    send(8'h14, 8'h10, 8'h80, 16'h0005, 8'h00, 0);  // zp bbc bit0, negative wrap R4 R6
    send(8'hA4, 8'h10, 8'h7F, 16'hFFF0, 8'h00, 1);  // zp bbs bit5 taken, wrap   R5
    send(8'h08, 8'h30, 8'h22, 16'h4000, 8'h77, 0);  // bit3 set: illegal R1
    send(8'h01, 8'h30, 8'h22, 16'h4000, 8'h77, 0);  // kind 01: illegal R1
    send(8'hE6, 8'h30, 8'h22, 16'h4000, 8'h77, 1);  // kind 10: illegal R1

    @(negedge clk);
    for (int a = 0; a < 256; a++)
      if (mem[a] != shadow[a]) chk(0, "R3/R4", "memory byte", mem[a], shadow[a]);
    chk(1, "R4", "memory image compared", 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule